// File: doc/BRIEF.md
# Port Reset Sequencer With Link-Down Reset

This block drives the five reset lines of a single PCIe port: the PHY, the PIPE interface, the MAC, the configuration space and the external fundamental-reset pin. Software owns a control word on a small register bus. Each of the five reset lines has its own active-low release bit in that word, so writing all zeros puts every domain back into reset. Each reset line has its own domain clock. A line asserts asynchronously and releases through a two-stage synchroniser in its domain.

A hardware path watches the link-up indication from the training logic. Software can arm this path through a three-bit enable field. Once armed, a registered up-to-down transition of the link pulls the MAC and configuration resets low for a fixed, parameterised number of cycles. The software control word is not modified, so the two domains come back on their own when the pulse ends. The other three lines are never touched by this path.

A status word reports link-up. The flag reads as zero whenever the MAC is held in reset. The usual bring-up is to release all five resets in one write and then poll the status flag until the link trains.

Top module: `port_reset_seq`

## Requirements
- R1: While the bus reset `rstN` is low, all five reset outputs are low and the control word reads back as zero.
- R2: The control word sits at word index 0. The release bits are: PHY in bit 0, PIPE in bit 1, MAC in bit 2, configuration in bit 3, fundamental-reset pin in bit 8. A 1 releases a line and a 0 holds it. Clearing a bit drives the matching output low without waiting for a domain clock edge.
- R3: The control word keeps only bits 0-3, bit 8 and bits 15:13; every other bit reads back as 0. A read of any index other than 0 or 1 returns 0.
- R4: A released line goes high on the second edge of its domain clock after the clock edge that wrote its bit to 1.
- R5: When bits 15:13 of the control word are all ones and the registered link-up drops from 1 to 0, the MAC and configuration outputs go low. They stay low for PULSE_CYC request cycles plus the two synchroniser cycles, which is PULSE_CYC+2 clock samples in total.
- R6: The link-down reset leaves the control word unchanged. It also leaves the PHY, PIPE and fundamental-reset outputs unchanged. None of these three outputs can fall unless the bus writes the control word.
- R7: The link-down reset fires only on the falling edge of link-up. Arming the field while the link is already down, and then waiting, produces no pulse.
- R8: When bits 15:13 hold any value other than 3'b111, a falling link produces no link-down reset.
- R9: Word index 1 is read-only status. Bit 10 is the registered link-up ANDed with the MAC reset output, so it reads 0 while the MAC is held in reset. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus and sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| domClk | input | 5 | Domain clocks: PHY, PIPE, MAC, configuration, pin (index 0..4) |
| busWrite | input | 1 | Write strobe for the register bus |
| busAddr | input | ADDR_W | Word index of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| linkUp | input | 1 | Link-up indication from the training logic |
| phyRstN | output | 1 | PHY reset, active low |
| pipeRstN | output | 1 | PIPE interface reset, active low |
| macRstN | output | 1 | MAC reset, active low |
| cfgRstN | output | 1 | Configuration space reset, active low |
| perstN | output | 1 | External fundamental-reset pin, active low |

## Verification
The bench measures the length of the link-down pulse by counting low samples on the MAC and configuration lines. A counter that is off by one, or that is not reloaded, gives a count other than PULSE_CYC+2. While the pulse runs, the bench reads the control word back and watches the PHY line. A design that clears software bits, or that resets every domain, would fail there. Three cases must stay quiet: arming the field while the link is already down, a partly set enable field, and a status read while the MAC is in reset. A level-triggered or single-bit-enabled design would pulse in the first two cases. A design that skips the MAC gate would report link-up in the third.

// File: rtl/port_rst_pkg.sv
package port_rst_pkg;
  localparam int PHY_BIT   = 0;
  localparam int PIPE_BIT  = 1;
  localparam int MAC_BIT   = 2;
  localparam int CFG_BIT   = 3;
  localparam int PERST_BIT = 8;
  localparam int LDEN_LO   = 13;
  localparam int LDEN_HI   = 15;
  localparam int LINK_BIT  = 10;
  localparam int NUM_DOM   = 5;
  // domain order on the reset vector
  localparam int DOM_PHY   = 0;
  localparam int DOM_PIPE  = 1;
  localparam int DOM_MAC   = 2;
  localparam int DOM_CFG   = 3;
  localparam int DOM_PERST = 4;
  localparam logic [15:0] KEEP_MASK = 16'hE10F;

  typedef struct packed {
    logic ctrlWr;   // write the control word this cycle
    logic autoRst;  // link-down reset pulse active
  } ctl_stb_t;
endpackage

// File: rtl/rst_sync_cell.sv
module rst_sync_cell #(
  parameter int STAGES = 2
) (
  input  logic domClk,
  input  logic reqN,
  output logic rstOutN
);
  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge domClk or negedge reqN) begin
    if (!reqN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[STAGES-2:0], 1'b1};
  end

  assign rstOutN = shiftQ[STAGES-1];
endmodule

// File: rtl/port_rst_ctl.sv
module port_rst_ctl
  import port_rst_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_IDX  = 0,
  parameter int PULSE_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              linkUp,
  input  logic [2:0]        ldEnField,
  output ctl_stb_t          stb,
  output logic              linkQ
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] pulseCnt;
  logic             fallNow;

  assign fallNow = linkQ && !linkUp && (ldEnField == 3'b111);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkQ    <= 1'b0;
      pulseCnt <= '0;
    end else begin
      linkQ <= linkUp;
      if (fallNow)
        pulseCnt <= CNT_W'(PULSE_CYC);
      else if (pulseCnt != '0)
        pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    stb.ctrlWr  = busWrite && (busAddr == ADDR_W'(CTRL_IDX));
    stb.autoRst = (pulseCnt != '0);
  end
endmodule

// File: rtl/port_rst_dp.sv
module port_rst_dp
  import port_rst_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int CTRL_IDX    = 0,
  parameter int STAT_IDX    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_stb_t           stb,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_DOM-1:0] domClk,
  input  logic               linkQ,
  output logic [DATA_W-1:0]  busRdata,
  output logic [2:0]         ldEnField,
  output logic [NUM_DOM-1:0] rstOut
);
  localparam logic [DATA_W-1:0] WR_MASK = DATA_W'(KEEP_MASK);

  logic [DATA_W-1:0]  ctrlQ;
  logic [DATA_W-1:0]  statW;
  logic [NUM_DOM-1:0] reqN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctrlQ <= '0;
    else if (stb.ctrlWr) ctrlQ <= busWdata & WR_MASK;
  end

  assign ldEnField = ctrlQ[LDEN_HI:LDEN_LO];

  always_comb begin
    reqN            = '0;
    reqN[DOM_PHY]   = ctrlQ[PHY_BIT];
    reqN[DOM_PIPE]  = ctrlQ[PIPE_BIT];
    reqN[DOM_MAC]   = ctrlQ[MAC_BIT] && !stb.autoRst;
    reqN[DOM_CFG]   = ctrlQ[CFG_BIT] && !stb.autoRst;
    reqN[DOM_PERST] = ctrlQ[PERST_BIT];
  end

  for (genvar gi = 0; gi < NUM_DOM; gi++) begin : g_sync
    rst_sync_cell #(.STAGES(SYNC_STAGES)) u_sync (
      .domClk (domClk[gi]),
      .reqN   (reqN[gi]),
      .rstOutN(rstOut[gi])
    );
  end

  always_comb begin
    statW           = '0;
    statW[LINK_BIT] = linkQ && rstOut[DOM_MAC];
  end

  always_comb begin
    if (busAddr == ADDR_W'(CTRL_IDX))      busRdata = ctrlQ;
    else if (busAddr == ADDR_W'(STAT_IDX)) busRdata = statW;
    else                                   busRdata = '0;
  end
endmodule

// File: rtl/port_reset_seq.sv
module port_reset_seq
  import port_rst_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int CTRL_IDX    = 0,
  parameter int STAT_IDX    = 1,
  parameter int PULSE_CYC   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        domClk,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              linkUp,
  output logic              phyRstN,
  output logic              pipeRstN,
  output logic              macRstN,
  output logic              cfgRstN,
  output logic              perstN
);
  ctl_stb_t           stbBus;
  logic               linkQ;
  logic [2:0]         ldEnField;
  logic [NUM_DOM-1:0] rstOut;
  logic               autoRstW;

  port_rst_ctl #(
    .ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX), .PULSE_CYC(PULSE_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .linkUp(linkUp), .ldEnField(ldEnField), .stb(stbBus), .linkQ(linkQ)
  );

  port_rst_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX),
    .STAT_IDX(STAT_IDX), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stbBus), .busAddr(busAddr),
    .busWdata(busWdata), .domClk(domClk), .linkQ(linkQ),
    .busRdata(busRdata), .ldEnField(ldEnField), .rstOut(rstOut)
  );

  assign autoRstW = stbBus.autoRst;
  assign phyRstN  = rstOut[DOM_PHY];
  assign pipeRstN = rstOut[DOM_PIPE];
  assign macRstN  = rstOut[DOM_MAC];
  assign cfgRstN  = rstOut[DOM_CFG];
  assign perstN   = rstOut[DOM_PERST];
endmodule

// File: rtl/port_rst_chk.sv
module port_rst_chk
  import port_rst_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int CTRL_IDX  = 0,
  parameter int STAT_IDX  = 1,
  parameter int PULSE_CYC = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              linkUp,
  input logic              phyRstN,
  input logic              pipeRstN,
  input logic              macRstN,
  input logic              cfgRstN,
  input logic              perstN,
  input logic              autoRst
);
  localparam int LEN_W = $clog2(PULSE_CYC + 1) + 1;

  logic             prevLink;
  logic [LEN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLink <= 1'b0;
      runLen   <= '0;
    end else begin
      prevLink <= linkUp;
      if (prevLink && !linkUp) runLen <= '0;
      else if (autoRst)        runLen <= runLen + 1'b1;
      else                     runLen <= '0;
    end
  end

  // R2
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(CTRL_IDX) && !busWdata[PHY_BIT] &&
     !busWdata[PIPE_BIT] && !busWdata[MAC_BIT] && !busWdata[CFG_BIT] &&
     !busWdata[PERST_BIT])
    |=> (!phyRstN && !pipeRstN && !macRstN && !cfgRstN && !perstN));

  // R5
  auto_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoRst |-> (!macRstN && !cfgRstN));

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoRst |-> (runLen < LEN_W'(PULSE_CYC)));

  // R6
  phy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite && phyRstN) |=> phyRstN);

  // R6
  pipe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite && pipeRstN) |=> pipeRstN);

  // R6
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite && perstN) |=> perstN);

  // R9
  status_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(STAT_IDX) && busRdata[LINK_BIT]) |-> macRstN);
endmodule

bind port_reset_seq port_rst_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX),
  .STAT_IDX(STAT_IDX), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .linkUp(linkUp),
  .phyRstN(phyRstN), .pipeRstN(pipeRstN), .macRstN(macRstN),
  .cfgRstN(cfgRstN), .perstN(perstN), .autoRst(autoRstW)
);

// File: tb/port_reset_seq_tb.sv
module port_reset_seq_tb;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int PULSE_CYC = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              linkUp = 1'b0;
  logic              phyRstN, pipeRstN, macRstN, cfgRstN, perstN;
  logic [4:0]        domClk;

  int  total = 0;
  int  fails = 0;
  bit  done  = 0;

  always #2.5 clk = ~clk;
  assign domClk = {5{clk}};

  port_reset_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .domClk(domClk), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .linkUp(linkUp), .phyRstN(phyRstN), .pipeRstN(pipeRstN),
    .macRstN(macRstN), .cfgRstN(cfgRstN), .perstN(perstN)
  );

  // {write data, expected readback, expected {pin,cfg,mac,pipe,phy}}
  localparam logic [52:0] VEC [0:5] = '{
    {32'h0000_010F, 16'h010F, 5'b11111},
    {32'h0000_0000, 16'h0000, 5'b00000},
    {32'h0000_0005, 16'h0005, 5'b00101},
    {32'hFFFF_FFFF, 16'hE10F, 5'b11111},
    {32'h0000_0102, 16'h0102, 5'b10010},
    {32'h0000_6008, 16'h6008, 5'b01000}
  };

  function automatic logic [4:0] outs();
    return {perstN, cfgRstN, macRstN, pipeRstN, phyRstN};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic countLow(output int macLow, output int cfgLow, output int phyLow);
    macLow = 0; cfgLow = 0; phyLow = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (!macRstN) macLow++;
      if (!cfgRstN) cfgLow++;
      if (!phyRstN) phyLow++;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    int ml, cl, pl;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", 32'(outs()), 32'h0);
    rd(0, rv);
    chk("R1 control readback in reset", rv, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs after reset release", 32'(outs()), 32'h0);

    // R2 R3 R4 vector walk
    for (int v = 0; v < 6; v++) begin
      wr(0, VEC[v][52:21]);
      rd(0, rv);
      chk("R3 control readback", rv, {16'h0, VEC[v][20:5]});
      @(negedge clk);
      // one edge after the write: a release is not yet visible (R4)
      if (v == 0) chk("R4 still low after one edge", 32'(outs()), 32'h0);
      @(negedge clk);
      chk("R2 R4 outputs", 32'(outs()), 32'(VEC[v][4:0]));
    end

    // R2 asynchronous assertion on clearing
    wr(0, 32'h0000_010F);
    repeat (2) @(negedge clk);
    wr(0, 32'h0);
    chk("R2 all low right after clearing write", 32'(outs()), 32'h0);

    // R3 unmapped index
    rd(3, rv);
    chk("R3 unmapped read", rv, 32'h0);

    // R9 status gated by MAC reset
    linkUp = 1'b1;
    wr(0, 32'h0000_010B);
    repeat (2) @(negedge clk);
    rd(1, rv);
    chk("R9 status while MAC held", rv, 32'h0);
    wr(0, 32'h0000_010F);
    repeat (2) @(negedge clk);
    rd(1, rv);
    chk("R9 status link up", rv, 32'h0000_0400);

    // R5 R6 link-down pulse
    wr(0, 32'h0000_E10F);
    repeat (2) @(negedge clk);
    chk("R5 all released before drop", 32'(outs()), 32'h1F);
    linkUp = 1'b0;
    countLow(ml, cl, pl);
    chk("R5 MAC low samples", 32'(ml), 32'(PULSE_CYC + 2));
    chk("R5 cfg low samples", 32'(cl), 32'(PULSE_CYC + 2));
    chk("R6 PHY untouched", 32'(pl), 32'h0);
    rd(0, rv);
    chk("R6 control word unchanged", rv, 32'h0000_E10F);
    chk("R6 pipe and pin high", {30'h0, perstN, pipeRstN}, 32'h3);

    // R7 arming while link is already down
    wr(0, 32'h0000_010F);
    wr(0, 32'h0000_E10F);
    countLow(ml, cl, pl);
    chk("R7 no pulse while link down", 32'(ml + cl), 32'h0);

    // R8 partial enable field
    linkUp = 1'b1;
    wr(0, 32'h0000_610F);
    repeat (3) @(negedge clk);
    linkUp = 1'b0;
    countLow(ml, cl, pl);
    chk("R8 no pulse with partial field", 32'(ml + cl), 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule